// File: doc/BRIEF.md
# Int8 Outer-Product Accumulator Tile

This block is the compute heart of a quantized matrix engine. It holds a tile of 8 by 8 signed 32-bit accumulators. On each step it takes two 256-bit operands. The "wide" operand carries weights and is spread along the rows. The "narrow" operand carries per-batch inputs and is spread along the columns. Every tile position forms a four-term signed 8-bit dot product from its row's wide lane and its column's narrow lane, then adds that result into its own accumulator.

A controller streams operand pairs with a step strobe and accumulates over as many steps as a reduction needs. It can zero the whole tile at once with a clear command, and it drains results one row at a time through a registered read port. Each read returns eight accumulators as one 256-bit word. Instruction decode, operand storage, memory traffic and output requantization belong to the surrounding logic.

Top module: `outer_mac_tile`

## Requirements
- R1: After reset every accumulator reads as zero and rd_valid is low.
- R2: On a step, accumulator (row i, column j) adds the dot product of wide lane i and narrow lane j. Lane k of an operand is bits [32k+31:32k]. Byte b of a lane is bits [8b+7:8b]. Byte b of the wide lane multiplies byte b of the narrow lane.
- R3: All operand bytes are two's-complement signed values in the range -128..127. The four 16-bit products are sign-extended before they are summed.
- R4: Accumulation wraps modulo 2^32. For example, 32768 steps that each add 65536 give 0x80000000, and 65536 such steps give 0.
- R5: Accumulators persist and keep summing across successive steps until a clear.
- R6: A clear sets all 64 accumulators to zero in one cycle. When clear and step occur in the same cycle, the clear wins and the step's products are discarded.
- R7: In a cycle with neither step nor clear, every accumulator keeps its value.
- R8: A read request with row index r makes rd_valid high in the next cycle. In that cycle rd_data holds row r as it stood before any step or clear in the request cycle. Column j is at bits [32j+31:32j].
- R9: rd_valid is low in every cycle that does not follow a read request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| step_valid | input | 1 | Accumulate the current operand pair this cycle |
| wide_op | input | 256 | Weight operand, lane i feeds row i |
| narrow_op | input | 256 | Batch operand, lane j feeds column j |
| clear_all | input | 1 | Zero all accumulators; overrides step_valid |
| rd_req | input | 1 | Request one row of accumulators |
| rd_row | input | 3 | Row index for the read request |
| rd_valid | output | 1 | rd_data holds a requested row |
| rd_data | output | 256 | Eight 32-bit accumulators of the requested row |

## Verification
The assertions check several things on every cycle. They check the read-port timing and that the returned row matches the tile state at the request. They check that a clear leaves the whole tile at zero, that the tile holds when there is neither a step nor a clear, and that the tile is zero and idle after reset. The arithmetic itself can only be shown by the bench's scenarios, which compare row reads against a model. These cover the lane and byte pairing of each cell, signed extremes, accumulation over several steps, wraparound after long accumulation, and a clear in the same cycle as a step.

// File: rtl/opm_pkg.sv
// Package: shared geometry for the int8 outer-product tile.
// Assumes: the defaults give 8 lanes of 4 bytes (256-bit operands) and 32-bit accumulators.
package opm_pkg;
    localparam int OPM_LANES  = 8;
    localparam int OPM_BYTES  = 4;
    localparam int OPM_BYTE_W = 8;
    localparam int OPM_ACC_W  = 32;
endpackage

// File: rtl/opm_dot4.sv
// Module: opm_dot4
// Purpose: combinational signed dot product of two lanes of NBYTES bytes each.
// Assumes: ACC_W is wide enough to hold a sign-extended full-width product.
module opm_dot4 #(
    parameter int NBYTES = opm_pkg::OPM_BYTES,
    parameter int BYTE_W = opm_pkg::OPM_BYTE_W,
    parameter int ACC_W  = opm_pkg::OPM_ACC_W
) (
    input  logic [NBYTES*BYTE_W-1:0] lane_a,
    input  logic [NBYTES*BYTE_W-1:0] lane_b,
    output logic [ACC_W-1:0]         dot_o
);
    localparam int PROD_W = 2 * BYTE_W;
    localparam int EXT_W  = ACC_W - PROD_W;

    logic signed [PROD_W-1:0] prod [NBYTES];

    // One signed multiplier per byte pair
    for (genvar b = 0; b < NBYTES; b++) begin : g_mul
        assign prod[b] = $signed(lane_a[b*BYTE_W +: BYTE_W]) *
                         $signed(lane_b[b*BYTE_W +: BYTE_W]);
    end

    // Sign-extend every product and reduce them into one sum
    always_comb begin
        dot_o = '0;
        for (int b = 0; b < NBYTES; b++) begin
            dot_o = dot_o + {{EXT_W{prod[b][PROD_W-1]}}, prod[b]};
        end
    end
endmodule

// File: rtl/opm_cell.sv
// Module: opm_cell
// Purpose: one accumulator position of the tile. It holds a wrapping ACC_W-bit sum.
// Assumes: clear has priority over step; reset is synchronous and active low.
module opm_cell #(
    parameter int NBYTES = opm_pkg::OPM_BYTES,
    parameter int BYTE_W = opm_pkg::OPM_BYTE_W,
    parameter int ACC_W  = opm_pkg::OPM_ACC_W
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     clear_i,
    input  logic                     step_i,
    input  logic [NBYTES*BYTE_W-1:0] wide_lane_i,
    input  logic [NBYTES*BYTE_W-1:0] narrow_lane_i,
    output logic [ACC_W-1:0]         acc_o
);
    logic [ACC_W-1:0] dot;

    opm_dot4 #(.NBYTES(NBYTES), .BYTE_W(BYTE_W), .ACC_W(ACC_W)) u_dot (
        .lane_a (wide_lane_i),
        .lane_b (narrow_lane_i),
        .dot_o  (dot)
    );

    // Accumulator register: clear wins, a step adds, otherwise hold
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_o <= '0;
        end else if (clear_i) begin
            acc_o <= '0;
        end else if (step_i) begin
            acc_o <= acc_o + dot;
        end
    end
endmodule

// File: rtl/opm_row_read.sv
// Module: opm_row_read
// Purpose: registered row selector. It returns one row of the flattened tile one cycle after a request.
// Assumes: the tile is flattened row-major, with column j of a row at bits [j*ACC_W +: ACC_W].
module opm_row_read #(
    parameter int LANES = opm_pkg::OPM_LANES,
    parameter int ACC_W = opm_pkg::OPM_ACC_W
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [LANES*LANES*ACC_W-1:0] tile_i,
    input  logic                       req_i,
    input  logic [$clog2(LANES)-1:0]   row_i,
    output logic                       valid_o,
    output logic [LANES*ACC_W-1:0]     data_o
);
    localparam int ROW_W = LANES * ACC_W;

    logic [ROW_W-1:0] rows [LANES];

    // Split the flat tile into addressable rows
    for (genvar r = 0; r < LANES; r++) begin : g_rows
        assign rows[r] = tile_i[r*ROW_W +: ROW_W];
    end

    // Capture the selected row and flag it valid for one cycle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_o <= 1'b0;
            data_o  <= '0;
        end else begin
            valid_o <= req_i;
            if (req_i) begin
                data_o <= rows[row_i];
            end
        end
    end
endmodule

// File: rtl/outer_mac_tile.sv
// Module: outer_mac_tile
// Purpose: LANES x LANES grid of int8 dot-product accumulators fed as an outer product.
//   Wide lane i reaches every cell of row i and narrow lane j reaches every cell of column j.
// Assumes: operands are stable in any cycle where step_valid is high; clear_all overrides step_valid.
module outer_mac_tile #(
    parameter int LANES  = opm_pkg::OPM_LANES,
    parameter int NBYTES = opm_pkg::OPM_BYTES,
    parameter int BYTE_W = opm_pkg::OPM_BYTE_W,
    parameter int ACC_W  = opm_pkg::OPM_ACC_W
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            step_valid,
    input  logic [LANES*NBYTES*BYTE_W-1:0]  wide_op,
    input  logic [LANES*NBYTES*BYTE_W-1:0]  narrow_op,
    input  logic                            clear_all,
    input  logic                            rd_req,
    input  logic [$clog2(LANES)-1:0]        rd_row,
    output logic                            rd_valid,
    output logic [LANES*ACC_W-1:0]          rd_data
);
    localparam int LANE_W = NBYTES * BYTE_W;
    localparam int CELLS  = LANES * LANES;

    logic [CELLS*ACC_W-1:0] acc_flat;

    // Grid of accumulator cells, row i by column j
    for (genvar i = 0; i < LANES; i++) begin : g_row
        for (genvar j = 0; j < LANES; j++) begin : g_col
            opm_cell #(.NBYTES(NBYTES), .BYTE_W(BYTE_W), .ACC_W(ACC_W)) u_cell (
                .clk           (clk),
                .rst_n         (rst_n),
                .clear_i       (clear_all),
                .step_i        (step_valid),
                .wide_lane_i   (wide_op[i*LANE_W +: LANE_W]),
                .narrow_lane_i (narrow_op[j*LANE_W +: LANE_W]),
                .acc_o         (acc_flat[(i*LANES+j)*ACC_W +: ACC_W])
            );
        end
    end

    opm_row_read #(.LANES(LANES), .ACC_W(ACC_W)) u_read (
        .clk     (clk),
        .rst_n   (rst_n),
        .tile_i  (acc_flat),
        .req_i   (rd_req),
        .row_i   (rd_row),
        .valid_o (rd_valid),
        .data_o  (rd_data)
    );
endmodule

// File: rtl/opm_tile_chk.sv
// Module: opm_tile_chk
// Purpose: cycle-by-cycle properties of the outer-product tile, bound to its top module.
// Assumes: the flattened tile layout of outer_mac_tile.
module opm_tile_chk #(
    parameter int LANES = opm_pkg::OPM_LANES,
    parameter int ACC_W = opm_pkg::OPM_ACC_W
) (
    input logic                         clk,
    input logic                         rst_n,
    input logic                         step_valid,
    input logic                         clear_all,
    input logic                         rd_req,
    input logic [$clog2(LANES)-1:0]     rd_row,
    input logic                         rd_valid,
    input logic [LANES*ACC_W-1:0]       rd_data,
    input logic [LANES*LANES*ACC_W-1:0] acc_flat
);
    localparam int ROW_W = LANES * ACC_W;

    logic [ROW_W-1:0] row_now;
    // Row that the current read request addresses
    assign row_now = acc_flat[int'(rd_row)*ROW_W +: ROW_W];

    p_reset_state_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (acc_flat == '0 && !rd_valid));

    p_clear_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
        clear_all |=> acc_flat == '0);

    p_hold_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!clear_all && !step_valid) |=> $stable(acc_flat));

    p_read_row_r8: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req |=> (rd_valid && rd_data == $past(row_now)));

    p_no_spurious_valid_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_req |=> !rd_valid);
endmodule

bind outer_mac_tile opm_tile_chk #(.LANES(LANES), .ACC_W(ACC_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .step_valid (step_valid),
    .clear_all  (clear_all),
    .rd_req     (rd_req),
    .rd_row     (rd_row),
    .rd_valid   (rd_valid),
    .rd_data    (rd_data),
    .acc_flat   (acc_flat)
);

// File: tb/sim_outer_mac_tile.sv
`timescale 1ns/1ps
// Scoreboard bench: the driver pushes expected rows, and the monitor pops and compares them.
module sim_outer_mac_tile;
    localparam int N  = 8;
    localparam int RW = N * 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          step_valid = 1'b0;
    logic [RW-1:0] wide_op = '0;
    logic [RW-1:0] narrow_op = '0;
    logic          clear_all = 1'b0;
    logic          rd_req = 1'b0;
    logic [2:0]    rd_row = '0;
    logic          rd_valid;
    logic [RW-1:0] rd_data;

    always #2.5 clk = ~clk;

    outer_mac_tile u0 (
        .clk(clk), .rst_n(rst_n), .step_valid(step_valid), .wide_op(wide_op),
        .narrow_op(narrow_op), .clear_all(clear_all), .rd_req(rd_req),
        .rd_row(rd_row), .rd_valid(rd_valid), .rd_data(rd_data)
    );

    logic [31:0]   model [N][N];
    logic [RW-1:0] exp_q [$];
    string         tag_q [$];
    int total = 0;
    int bad = 0;
    bit finished = 1'b0;

    function automatic logic [31:0] dot(input logic [31:0] a, input logic [31:0] b);
        int s = 0;
        for (int k = 0; k < 4; k++) begin
            s += int'($signed(a[8*k +: 8])) * int'($signed(b[8*k +: 8]));
        end
        return 32'(s);
    endfunction

    function automatic logic [RW-1:0] row_bits(input int r);
        logic [RW-1:0] v;
        for (int j = 0; j < N; j++) v[32*j +: 32] = model[r][j];
        return v;
    endfunction

    function automatic logic [RW-1:0] rand256();
        logic [RW-1:0] v;
        for (int k = 0; k < 8; k++) v[32*k +: 32] = $urandom;
        return v;
    endfunction

    // Drive one cycle, queue any expected row, then advance the model
    task automatic cyc(input logic v, input logic [RW-1:0] w, input logic [RW-1:0] n,
                       input logic c, input logic rq, input int r, input string tag);
        @(negedge clk);
        step_valid = v; wide_op = w; narrow_op = n;
        clear_all = c; rd_req = rq; rd_row = 3'(r);
        if (rq) begin
            exp_q.push_back(row_bits(r));
            tag_q.push_back(tag);
        end
        for (int i = 0; i < N; i++)
            for (int j = 0; j < N; j++)
                if (c) model[i][j] = '0;
                else if (v) model[i][j] = model[i][j] + dot(w[32*i +: 32], n[32*j +: 32]);
    endtask

    task automatic read_all(input string tag);
        for (int r = 0; r < N; r++) cyc(1'b0, '0, '0, 1'b0, 1'b1, r, tag);
        cyc(1'b0, '0, '0, 1'b0, 1'b0, 0, tag);
    endtask

    // Monitor: compare rd_valid and rd_data against the scoreboard, clear of the edges
    always @(posedge clk) begin
        #1;
        if (rst_n && !finished) begin
            if (exp_q.size() > 0) begin
                logic [RW-1:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                total++;
                if (!rd_valid || rd_data !== e) begin
                    bad++;
                    $display("FAIL %s: rd_valid=%0b rd_data=%h expected %h", t, rd_valid, rd_data, e);
                end
            end else begin
                total++;
                if (rd_valid !== 1'b0) begin
                    bad++;
                    $display("FAIL R9: rd_valid=%0b expected 0", rd_valid);
                end
            end
        end
    end

    // Watchdog: a hung run counts as a failure and still prints the summary
    initial begin
        #(200000 * 5);
        if (!finished) begin
            finished = 1'b1;
            total++; bad++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [RW-1:0] w, n;
        for (int i = 0; i < N; i++) for (int j = 0; j < N; j++) model[i][j] = '0;
        repeat (3) @(posedge clk);
        #1;
        total++;
        if (rd_valid !== 1'b0) begin
            bad++;
            $display("FAIL R1: rd_valid=%0b during reset expected 0", rd_valid);
        end
        @(negedge clk); rst_n = 1'b1;

        // R1: tile reads zero after reset
        read_all("R1 reset zero");

        // R2/R3: distinct bytes per lane, including negatives
        for (int l = 0; l < N; l++)
            for (int b = 0; b < 4; b++) begin
                w[32*l + 8*b +: 8] = 8'(l * 9 + b * 3 - 20);
                n[32*l + 8*b +: 8] = 8'(60 - l * 17 + b * 5);
            end
        cyc(1'b1, w, n, 1'b0, 1'b0, 0, "R2");
        read_all("R2 lane pairing");

        // R3: signed extremes
        w = {8{8'h80, 8'h7f, 8'h80, 8'h01}};
        n = {8{8'h80, 8'h80, 8'h7f, 8'hff}};
        cyc(1'b0, '0, '0, 1'b1, 1'b0, 0, "R6");
        cyc(1'b1, w, n, 1'b0, 1'b0, 0, "R3");
        read_all("R3 signed extremes");

        // R5/R8: random steps with same-cycle reads returning the pre-step row
        for (int s = 0; s < 12; s++) cyc(1'b1, rand256(), rand256(), 1'b0, 1'b1, s % N, "R8 read before step");
        read_all("R5 accumulate");

        // R7: idle cycles leave the tile unchanged
        repeat (5) cyc(1'b0, rand256(), rand256(), 1'b0, 1'b0, 0, "R7");
        read_all("R7 hold");

        // R6: clear together with a step discards the products
        cyc(1'b1, rand256(), rand256(), 1'b1, 1'b1, 2, "R6 read before clear");
        read_all("R6 clear wins");
        cyc(1'b1, rand256(), rand256(), 1'b0, 1'b0, 0, "R6");
        cyc(1'b0, '0, '0, 1'b1, 1'b0, 0, "R6");
        read_all("R6 clear alone");

        // R4: 65536 per step; wraps to 0x80000000 and then to zero
        w = {32{8'h80}};
        n = {32{8'h80}};
        for (int s = 0; s < 32768; s++) cyc(1'b1, w, n, 1'b0, 1'b0, 0, "R4");
        cyc(1'b0, '0, '0, 1'b0, 1'b1, 3, "R4 half wrap");
        cyc(1'b0, '0, '0, 1'b0, 1'b0, 0, "R4");
        total++;
        if (model[3][5] !== 32'h8000_0000) begin
            bad++;
            $display("FAIL R4: model=%h expected 80000000", model[3][5]);
        end
        for (int s = 0; s < 32768; s++) cyc(1'b1, w, n, 1'b0, 1'b0, 0, "R4");
        cyc(1'b0, '0, '0, 1'b0, 1'b1, 6, "R4 full wrap");
        repeat (3) cyc(1'b0, '0, '0, 1'b0, 1'b0, 0, "R9");

        finished = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule